// File: doc/BRIEF.md
# Tagged Multi-History Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines an untagged base table of 2-bit saturating counters with three tagged tables. Each tagged table looks at a longer slice of global branch history than the one before it: 4, 16 and 64 outcomes. Every tagged entry holds a valid flag, a 3-bit direction counter, a 10-bit partial tag and a 2-bit usefulness field. Among the tagged tables whose tag matches, the one with the longest history supplies the prediction. The next-shorter match, or the base table when there is none, supplies an alternate prediction. The alternate overrides the provider when the provider's counter is weak and the alternate is confident.

The caller presents the word address of the branch (`fetchWord`, branch PC bits 19:2), and the prediction and provider appear combinationally in the same cycle. When the outcome of that branch is known, the caller holds the same `fetchWord`, raises `resolveValid` and drives `resolveTaken`. On that clock edge the block trains the provider, adjusts usefulness, allocates or ages entries in longer-history tables after a misprediction, and shifts the outcome into the global history.

Top module: `tage_predictor`

## Requirements
- R1: After reset every tagged entry is invalid with usefulness 0, every base counter holds 2 (weakly taken), and the history is all zeros. Until the first resolve, every address therefore predicts taken with provider 0.
- R2: Base counters are 2-bit saturating (taken adds 1 up to 3, not-taken subtracts 1 down to 0) and predict taken when bit 1 is set. A base counter is trained only when the base table is the provider. It is confident at values 0 and 3.
- R3: The history register holds the most recent outcome in bit 0. Table k (k = 1, 2, 3) uses the newest 4, 16 or 64 history bits. Its 8-bit index is fetchWord[7:0] XOR the XOR of those bits taken in 8-bit chunks. Its tag is fetchWord[17:8] XOR the same bits taken in 10-bit chunks. A table hits when its indexed entry is valid and the stored tag equals the computed tag.
- R4: `providerId` is the highest-numbered hitting table, or 0 (the base) when no tagged table hits.
- R5: The alternate is the highest hitting table below the provider, or the base. When the provider is tagged, its counter is 3 or 4, and the alternate is confident, `predTaken` is the alternate's direction. Otherwise it is the provider's direction.
- R6: A tagged counter is 3 bits, saturates at 0 and 7, predicts taken at 4 or more, and is trained on every resolve for which its table is the provider.
- R7: When the provider is tagged and its direction differs from the alternate's, the provider's usefulness rises by 1 (saturating at 3) if the provider was right, and falls by 1 (saturating at 0) if it was wrong.
- R8: When `predTaken` differs from the resolved outcome and the provider is below table 3, the lowest-numbered table above the provider whose indexed usefulness is 0 receives a new entry. The entry is valid, carries the computed tag, has usefulness 0, and has counter 4 when the branch was taken or 3 when it was not. No entry is allocated after a correct prediction.
- R9: When a misprediction finds no table above the provider with usefulness 0, nothing is allocated. Instead the indexed usefulness of each table above the provider falls by 1.
- R10: Each resolve shifts its outcome into history bit 0. Without `resolveValid`, no table and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchWord | input | 18 | Branch PC bits 19:2 for lookup and update |
| resolveValid | input | 1 | Apply the update for `fetchWord` at this edge |
| resolveTaken | input | 1 | Resolved direction, 1 = taken |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| providerId | output | 2 | Providing table: 0 = base, 1..3 = tagged table |

## Verification
On every cycle the checker confirms that the reported provider really hits and that no longer table hits. It also confirms that allocation and usefulness aging only ever target tables above the provider, that at most one table is allocated, that aging and allocation never coincide, that a correct prediction changes nothing beyond training, and that an idle cycle issues no write. The contents of the entries are not visible to the checker. The counter values, the folding of history into index and tag, the alternate override and the usefulness bookkeeping can only be shown by the bench's sequences, where they become visible through later predictions and provider choices.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int NUM_TAGGED = 3;
  localparam int IDX_W      = 8;
  localparam int TAG_W      = 10;
  localparam int CTR_W      = 3;
  localparam int USE_W      = 2;
  localparam int BASE_W     = 2;
  localparam int HIST_BASE  = 4;
  localparam int HIST_STEP  = 2;   // log2 of the history length ratio between tables
  localparam int HIST_W     = HIST_BASE << (HIST_STEP * (NUM_TAGGED - 1));
  localparam int PC_W       = IDX_W + TAG_W;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int PROV_W     = $clog2(NUM_TAGGED + 1);
  localparam logic [CTR_W-1:0]  CTR_WEAK_T  = CTR_W'(1 << (CTR_W - 1));
  localparam logic [CTR_W-1:0]  CTR_WEAK_N  = CTR_WEAK_T - 1'b1;
  localparam logic [BASE_W-1:0] BASE_RESET  = BASE_W'(1 << (BASE_W - 1));

  typedef struct packed {
    logic                  trainBase;
    logic [NUM_TAGGED-1:0] trainSel;
    logic                  usefulUp;
    logic                  usefulDown;
    logic [NUM_TAGGED-1:0] allocSel;
    logic [NUM_TAGGED-1:0] decaySel;
    logic                  taken;
    logic                  shiftHist;
  } strobe_t;

  function automatic logic [IDX_W-1:0] foldToIndex(logic [HIST_W-1:0] h, int len);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_W; i++)
      if (i < len) acc[i % IDX_W] = acc[i % IDX_W] ^ h[i];
    return acc;
  endfunction

  function automatic logic [TAG_W-1:0] foldToTag(logic [HIST_W-1:0] h, int len);
    logic [TAG_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_W; i++)
      if (i < len) acc[i % TAG_W] = acc[i % TAG_W] ^ h[i];
    return acc;
  endfunction
endpackage

// File: rtl/tage_datapath.sv
module tage_datapath
  import tage_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [PC_W-1:0]                       fetchWord,
  input  strobe_t                               strobe,
  output logic [NUM_TAGGED-1:0]                 hitVec,
  output logic [NUM_TAGGED-1:0][CTR_W-1:0]      ctrOut,
  output logic [NUM_TAGGED-1:0][USE_W-1:0]      useOut,
  output logic [BASE_W-1:0]                     baseCtr
);
  logic [HIST_W-1:0] histReg;
  logic [IDX_W-1:0]  baseIdx;
  logic [BASE_W-1:0] baseMem [DEPTH];

  assign baseIdx = fetchWord[IDX_W-1:0];
  assign baseCtr = baseMem[baseIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
      for (int e = 0; e < DEPTH; e++) baseMem[e] <= BASE_RESET;
    end else begin
      if (strobe.shiftHist) histReg <= {histReg[HIST_W-2:0], strobe.taken};
      if (strobe.trainBase) begin
        if (strobe.taken && baseCtr != '1)       baseMem[baseIdx] <= baseCtr + 1'b1;
        else if (!strobe.taken && baseCtr != '0) baseMem[baseIdx] <= baseCtr - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_TAGGED; k++) begin : g_tbl
    localparam int LEN = HIST_BASE << (HIST_STEP * k);
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tagCalc;
    logic             validMem [DEPTH];
    logic [TAG_W-1:0] tagMem   [DEPTH];
    logic [CTR_W-1:0] ctrMem   [DEPTH];
    logic [USE_W-1:0] useMem   [DEPTH];
    logic [CTR_W-1:0] ctrNow;
    logic [USE_W-1:0] useNow;

    assign idx       = fetchWord[IDX_W-1:0] ^ foldToIndex(histReg, LEN);
    assign tagCalc   = fetchWord[IDX_W +: TAG_W] ^ foldToTag(histReg, LEN);
    assign ctrNow    = ctrMem[idx];
    assign useNow    = useMem[idx];
    assign hitVec[k] = validMem[idx] && (tagMem[idx] == tagCalc);
    assign ctrOut[k] = ctrNow;
    assign useOut[k] = useNow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < DEPTH; e++) begin
          validMem[e] <= 1'b0;
          tagMem[e]   <= '0;
          ctrMem[e]   <= CTR_WEAK_N;
          useMem[e]   <= '0;
        end
      end else if (strobe.allocSel[k]) begin
        validMem[idx] <= 1'b1;
        tagMem[idx]   <= tagCalc;
        ctrMem[idx]   <= strobe.taken ? CTR_WEAK_T : CTR_WEAK_N;
        useMem[idx]   <= '0;
      end else if (strobe.trainSel[k]) begin
        if (strobe.taken && ctrNow != '1)       ctrMem[idx] <= ctrNow + 1'b1;
        else if (!strobe.taken && ctrNow != '0) ctrMem[idx] <= ctrNow - 1'b1;
        if (strobe.usefulUp && useNow != '1)        useMem[idx] <= useNow + 1'b1;
        else if (strobe.usefulDown && useNow != '0) useMem[idx] <= useNow - 1'b1;
      end else if (strobe.decaySel[k] && useNow != '0) begin
        useMem[idx] <= useNow - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tage_control.sv
module tage_control
  import tage_pkg::*;
(
  input  logic                             resolveValid,
  input  logic                             resolveTaken,
  input  logic [NUM_TAGGED-1:0]            hitVec,
  input  logic [NUM_TAGGED-1:0][CTR_W-1:0] ctrOut,
  input  logic [NUM_TAGGED-1:0][USE_W-1:0] useOut,
  input  logic [BASE_W-1:0]                baseCtr,
  output logic                             predTaken,
  output logic [PROV_W-1:0]                providerId,
  output strobe_t                          strobe
);
  logic provPred, provSure, altPred, altSure, useAlt, mispred, placed;
  int   provNum;

  // Ascending scan: each new hit demotes the previous provider to alternate.
  always_comb begin
    provNum  = 0;
    provPred = baseCtr[BASE_W-1];
    provSure = (baseCtr == '0) || (baseCtr == '1);
    altPred  = provPred;
    altSure  = provSure;
    for (int k = 0; k < NUM_TAGGED; k++) begin
      if (hitVec[k]) begin
        altPred  = provPred;
        altSure  = provSure;
        provPred = ctrOut[k][CTR_W-1];
        provSure = !((ctrOut[k] == CTR_WEAK_N) || (ctrOut[k] == CTR_WEAK_T));
        provNum  = k + 1;
      end
    end
    useAlt    = (provNum != 0) && !provSure && altSure;
    predTaken = useAlt ? altPred : provPred;
  end

  assign providerId = PROV_W'(provNum);

  always_comb begin
    strobe  = '0;
    mispred = (predTaken != resolveTaken);
    placed  = 1'b0;
    if (resolveValid) begin
      strobe.taken     = resolveTaken;
      strobe.shiftHist = 1'b1;
      strobe.trainBase = (provNum == 0);
      for (int k = 0; k < NUM_TAGGED; k++) strobe.trainSel[k] = (provNum == k + 1);
      if (provNum != 0 && provPred != altPred) begin
        strobe.usefulUp   = (provPred == resolveTaken);
        strobe.usefulDown = (provPred != resolveTaken);
      end
      if (mispred) begin
        for (int k = 0; k < NUM_TAGGED; k++) begin
          if (k + 1 > provNum && !placed && useOut[k] == '0) begin
            strobe.allocSel[k] = 1'b1;
            placed = 1'b1;
          end
        end
        if (!placed)
          for (int k = 0; k < NUM_TAGGED; k++) strobe.decaySel[k] = (k + 1 > provNum);
      end
    end
  end
endmodule

// File: rtl/tage_predictor.sv
module tage_predictor
  import tage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchWord,
  input  logic              resolveValid,
  input  logic              resolveTaken,
  output logic              predTaken,
  output logic [PROV_W-1:0] providerId
);
  strobe_t                          strobe;
  logic [NUM_TAGGED-1:0]            hitVec;
  logic [NUM_TAGGED-1:0][CTR_W-1:0] ctrOut;
  logic [NUM_TAGGED-1:0][USE_W-1:0] useOut;
  logic [BASE_W-1:0]                baseCtr;

  tage_datapath u_dp (
    .clk(clk), .rstN(rstN), .fetchWord(fetchWord), .strobe(strobe),
    .hitVec(hitVec), .ctrOut(ctrOut), .useOut(useOut), .baseCtr(baseCtr)
  );

  tage_control u_ctl (
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .hitVec(hitVec), .ctrOut(ctrOut), .useOut(useOut), .baseCtr(baseCtr),
    .predTaken(predTaken), .providerId(providerId), .strobe(strobe)
  );
endmodule

// File: rtl/tage_checker.sv
module tage_checker
  import tage_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  resolveValid,
  input logic                  resolveTaken,
  input logic                  predTaken,
  input logic [PROV_W-1:0]     providerId,
  input logic [NUM_TAGGED-1:0] hitVec,
  input strobe_t               strobe
);
  AST_PROVIDER_HITS: assert property (@(posedge clk) disable iff (!rstN)
    (providerId != 0) |-> hitVec[providerId - 1]); // R4
  AST_NO_LONGER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec >> providerId) == '0); // R4
  AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.allocSel)); // R8
  AST_ALLOC_ABOVE_PROVIDER: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.allocSel | strobe.decaySel) & NUM_TAGGED'((1 << providerId) - 1)) == '0); // R8
  AST_CORRECT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && predTaken == resolveTaken) |-> (strobe.allocSel == '0 && strobe.decaySel == '0)); // R8
  AST_ALLOC_XOR_DECAY: assert property (@(posedge clk) disable iff (!rstN)
    !((strobe.allocSel != '0) && (strobe.decaySel != '0))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |-> (strobe == '0)); // R10
endmodule

bind tage_predictor tage_checker u_chk (
  .clk(clk), .rstN(rstN), .resolveValid(resolveValid), .resolveTaken(resolveTaken),
  .predTaken(predTaken), .providerId(providerId), .hitVec(hitVec), .strobe(strobe)
);

// File: tb/sim_tage_predictor.sv
module sim_tage_predictor;
  import tage_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   fetchWord = '0;
  logic              resolveValid = 1'b0;
  logic              resolveTaken = 1'b0;
  logic              predTaken;
  logic [PROV_W-1:0] providerId;

  int nChecks = 0;
  int nFail   = 0;
  int nDecay  = 0;
  int nAlloc  = 0;
  string lastEv = "";

  // reference state
  logic [1:0]  mBase  [DEPTH];
  logic        mValid [NUM_TAGGED][DEPTH];
  logic [9:0]  mTag   [NUM_TAGGED][DEPTH];
  logic [2:0]  mCtr   [NUM_TAGGED][DEPTH];
  logic [1:0]  mUse   [NUM_TAGGED][DEPTH];
  logic [63:0] mHist;

  tage_predictor u0 (
    .clk(clk), .rstN(rstN), .fetchWord(fetchWord), .resolveValid(resolveValid),
    .resolveTaken(resolveTaken), .predTaken(predTaken), .providerId(providerId)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] mFold(logic [63:0] h, int len, int w);
    logic [63:0] m;
    logic [9:0]  acc;
    m   = (len >= 64) ? h : (h & ((64'd1 << len) - 64'd1));
    acc = '0;
    for (int c = 0; c < 64; c += w) acc ^= 10'((m >> c) & ((64'd1 << w) - 64'd1));
    return acc;
  endfunction

  function automatic int mLen(int k);
    return 4 << (2 * (k - 1));
  endfunction

  function automatic int mIdx(int k, logic [PC_W-1:0] w);
    return int'(w[7:0] ^ 8'(mFold(mHist, mLen(k), 8)));
  endfunction

  function automatic logic [9:0] mTagOf(int k, logic [PC_W-1:0] w);
    return w[17:8] ^ mFold(mHist, mLen(k), 10);
  endfunction

  function automatic bit mHit(int k, logic [PC_W-1:0] w);
    return mValid[k-1][mIdx(k, w)] && (mTag[k-1][mIdx(k, w)] == mTagOf(k, w));
  endfunction

  task automatic mLookup(input logic [PC_W-1:0] w, output logic fin, output int prov,
                         output logic pPred, output logic aPred);
    int alt;
    logic [1:0] b;
    logic [2:0] pc3, ac3;
    bit pWeak, aSure;
    prov = 0; alt = 0;
    for (int k = NUM_TAGGED; k >= 1; k--) if (prov == 0 && mHit(k, w)) prov = k;
    for (int k = prov - 1; k >= 1; k--) if (alt == 0 && mHit(k, w)) alt = k;
    b = mBase[w[7:0]];
    if (alt == 0) begin aPred = b[1]; aSure = (b == 2'd0 || b == 2'd3); end
    else begin ac3 = mCtr[alt-1][mIdx(alt, w)]; aPred = (ac3 >= 3'd4); aSure = !(ac3 == 3'd3 || ac3 == 3'd4); end
    if (prov == 0) begin pPred = b[1]; pWeak = 0; end
    else begin pc3 = mCtr[prov-1][mIdx(prov, w)]; pPred = (pc3 >= 3'd4); pWeak = (pc3 == 3'd3 || pc3 == 3'd4); end
    fin = (prov != 0 && pWeak && aSure) ? aPred : pPred;
  endtask

  task automatic mUpdate(input logic [PC_W-1:0] w, input logic t);
    logic fin, pp, ap;
    int prov, chosen, ix;
    int idxs [NUM_TAGGED+1];
    logic [9:0] tags [NUM_TAGGED+1];
    mLookup(w, fin, prov, pp, ap);
    for (int k = 1; k <= NUM_TAGGED; k++) begin idxs[k] = mIdx(k, w); tags[k] = mTagOf(k, w); end
    lastEv = "";
    if (prov == 0) begin
      if (t && mBase[w[7:0]] != 2'd3) mBase[w[7:0]] += 2'd1;
      else if (!t && mBase[w[7:0]] != 2'd0) mBase[w[7:0]] -= 2'd1;
    end else begin
      ix = idxs[prov];
      if (t && mCtr[prov-1][ix] != 3'd7) mCtr[prov-1][ix] += 3'd1;
      else if (!t && mCtr[prov-1][ix] != 3'd0) mCtr[prov-1][ix] -= 3'd1;
      if (pp != ap) begin
        if (pp == t && mUse[prov-1][ix] != 2'd3) mUse[prov-1][ix] += 2'd1;
        else if (pp != t && mUse[prov-1][ix] != 2'd0) mUse[prov-1][ix] -= 2'd1;
      end
    end
    if (fin != t && prov < NUM_TAGGED) begin
      chosen = 0;
      for (int k = prov + 1; k <= NUM_TAGGED; k++)
        if (chosen == 0 && mUse[k-1][idxs[k]] == 2'd0) chosen = k;
      if (chosen != 0) begin
        mValid[chosen-1][idxs[chosen]] = 1'b1;
        mTag[chosen-1][idxs[chosen]]   = tags[chosen];
        mCtr[chosen-1][idxs[chosen]]   = t ? 3'd4 : 3'd3;
        mUse[chosen-1][idxs[chosen]]   = 2'd0;
        lastEv = "R8"; nAlloc++;
      end else begin
        for (int k = prov + 1; k <= NUM_TAGGED; k++)
          if (mUse[k-1][idxs[k]] != 2'd0) mUse[k-1][idxs[k]] -= 2'd1;
        lastEv = "R9"; nDecay++;
      end
    end
    mHist = {mHist[62:0], t};
  endtask

  task automatic check(input string req, input logic aPred, input int aProv,
                       input logic ePred, input int eProv);
    nChecks++;
    if (aPred !== ePred || aProv != eProv) begin
      nFail++;
      $display("FAIL %s pred/provider actual=%0d/%0d expected=%0d/%0d", req, aPred, aProv, ePred, eProv);
    end
  endtask

  // Look up without updating.
  task automatic peek(input logic [PC_W-1:0] w, input logic ePred, input int eProv, input string req);
    @(negedge clk);
    fetchWord = w; resolveValid = 1'b0; resolveTaken = ~ePred;
    #1 check(req, predTaken, int'(providerId), ePred, eProv);
  endtask

  // Look up and resolve; expectation from the reference state.
  task automatic step(input logic [PC_W-1:0] w, input logic t, input string req);
    logic ep, pp, ap;
    int pv;
    mLookup(w, ep, pv, pp, ap);
    @(negedge clk);
    fetchWord = w; resolveValid = 1'b1; resolveTaken = t;
    #1 check(req, predTaken, int'(providerId), ep, pv);
    @(posedge clk);
    mUpdate(w, t);
  endtask

  // Look up and resolve; expectation worked out by hand.
  task automatic stepHand(input logic [PC_W-1:0] w, input logic t, input logic ePred,
                          input int eProv, input string req);
    @(negedge clk);
    fetchWord = w; resolveValid = 1'b1; resolveTaken = t;
    #1 check(req, predTaken, int'(providerId), ePred, eProv);
    @(posedge clk);
    mUpdate(w, t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [PC_W-1:0] w;
    logic t;
    int loopCnt;
    mHist = '0;
    for (int e = 0; e < DEPTH; e++) begin
      mBase[e] = 2'd2;
      for (int k = 0; k < NUM_TAGGED; k++) begin
        mValid[k][e] = 1'b0; mTag[k][e] = '0; mCtr[k][e] = 3'd3; mUse[k][e] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state seen at several addresses
    for (int i = 0; i < 8; i++) peek(PC_W'(i * 18'h04A51 + 3), 1'b1, 0, "R1 reset");

    // R10: idle cycles with not-taken on the inputs must not train anything
    @(negedge clk);
    fetchWord = 18'h12345; resolveValid = 1'b0; resolveTaken = 1'b0;
    repeat (6) @(negedge clk);
    peek(18'h12345, 1'b1, 0, "R10 idle leaves base");
    peek(18'h00003, 1'b1, 0, "R10 idle leaves base");

    // Hand-worked sequence with zero history
    stepHand(18'h12345, 1'b0, 1'b1, 0, "R1 R8 first miss allocates table 1");
    stepHand(18'h12345, 1'b0, 1'b0, 1, "R8 R4 new weak-not-taken entry provides");
    stepHand(18'h12345, 1'b1, 1'b0, 1, "R6 counter trained down to 2");
    // history is now 1: all tagged lookups for this address miss, base counter is 1
    stepHand(18'h12345, 1'b1, 1'b0, 0, "R3 R2 history change moves index, base trained");

    // R2: base saturation on a fresh address (taken is correct, nothing allocates)
    for (int i = 0; i < 4; i++) step(18'h3C0F0, 1'b1, "R2 base saturates up");

    // Sweep 1: fixed branch population with distinct behaviours
    lfsr = 16'hACE1;
    loopCnt = 0;
    for (int s = 0; s < 3000; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (s % 5)
        0: begin w = 18'h00A10; t = (loopCnt % 4) != 3; loopCnt++; end  // loop exit every 4th
        1: begin w = 18'h1FF21; t = s[0]; end                             // alternating
        2: begin w = 18'h00033; t = 1'b1; end                             // aliases on base with next
        3: begin w = 18'h2A433; t = 1'b0; end
        default: begin w = 18'h05566; t = lfsr[0]; end
      endcase
      step(w, t, (lastEv == "R9") ? "R9 lookup after aging" : "R3 R4 R5 R6 R7 R8 sweep");
    end

    // Sweep 2: many addresses, random outcomes, crowds the tagged tables
    for (int s = 0; s < 3000; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = {lfsr[11:8], 6'd0, lfsr[5:2], 4'd0};
      t = lfsr[1] ^ lfsr[7];
      step(w, t, (lastEv == "R9") ? "R9 lookup after aging" : "R5 R7 R8 crowded sweep");
    end

    // Final idle check: a frozen address keeps its prediction
    begin
      logic ep, pp, ap;
      int pv;
      mLookup(18'h00A10, ep, pv, pp, ap);
      @(negedge clk);
      fetchWord = 18'h00A10; resolveValid = 1'b0; resolveTaken = ~ep;
      repeat (4) @(negedge clk);
      peek(18'h00A10, ep, pv, "R10 idle after training");
    end

    $display("allocations %0d, agings %0d", nAlloc, nDecay);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule